// File: doc/BRIEF.md
# Serial EEPROM Configuration Loader

This block runs once after reset and fills the hub's descriptor settings from a small serial EEPROM. It walks the whole device one 16-bit word at a time with a three-wire serial read: select, clock and command out, data back. From the returned image it picks out the vendor and product identifiers, the removable-port mask, the downstream port count, the maximum power value and the lengths of the vendor, product and serial strings. It then checks the image before it uses any of those values.

If the image fails its checksum, or the data line never goes low (no device fitted), every field takes a built-in default value instead. The four EEPROM lines are borrowed from the status LED pins of downstream ports 1 and 2. While the load runs the block drives them as EEPROM signals. Once the done flag rises they carry the LED drive again and stay that way until the next reset.

Top module: `eeprom_cfg_loader`

## Requirements
- R1: While reset is held and during loading, `load_done` is 0 and every configuration output shows its default value.
- R2: Each word read raises chip select (driven on `pin_p1_amber`, active high), then sends 9 bits on `pin_p2_amber`, each stable at a rising edge of `pin_p1_green`: a 1 start bit, the read opcode `10`, then a 6-bit word address sent MSB first. Addresses run from 0 to 63 in ascending order, one read per address.
- R3: After the command, the 16 data bits are taken MSB first from `pin_p2_green_i` on the falling clock edges of the next 16 bit periods. Each read uses exactly 25 rising clock edges. The word at address a holds byte offset 2a in bits 7:0 and byte offset 2a+1 in bits 15:8.
- R4: Byte offsets map to fields as follows. The vendor ID is {01h, 00h} and the product ID is {03h, 02h}. 06h gives the removable mask, 07h the port count and 08h the maximum power. 10h, 40h and 70h give the vendor, product and serial string lengths.
- R5: The image is accepted when byte 04h equals (256 − (b00h + b01h + b02h + b03h)) mod 256. The case where that sum is 0 needs a checksum byte of 00h. An accepted image drives every field with its loaded value.
- R6: When the checksum byte does not match, every field reports its default value.
- R7: When all 64 words read back as FFFFh (data line held high, no device), every field reports its default value.
- R8: `load_done` rises after the last word has been read, stays high until reset, and the configuration outputs do not change while it is high.
- R9: While loading, `pin_p2_green_oe` is 0 and the other three pins carry the EEPROM signals. Once `load_done` is high, `pin_p2_green_oe` is 1 and `pin_p1_green`, `pin_p1_amber`, `pin_p2_amber` and `pin_p2_green_o` follow the matching LED inputs.
- R10: During loading, the clock stays low whenever chip select is low, and chip select stays low for at least one clock period between words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset; a load starts when it is released |
| led_p1_green | input | 1 | LED drive for port 1 green |
| led_p1_amber | input | 1 | LED drive for port 1 amber |
| led_p2_amber | input | 1 | LED drive for port 2 amber |
| led_p2_green | input | 1 | LED drive for port 2 green |
| pin_p1_green | output | 1 | Port 1 green pin; EEPROM clock while loading |
| pin_p1_amber | output | 1 | Port 1 amber pin; EEPROM chip select while loading |
| pin_p2_amber | output | 1 | Port 2 amber pin; serial data to the EEPROM while loading |
| pin_p2_green_o | output | 1 | Port 2 green pin output value |
| pin_p2_green_oe | output | 1 | Port 2 green pin output enable (0 while loading) |
| pin_p2_green_i | input | 1 | Port 2 green pin input; serial data from the EEPROM |
| load_done | output | 1 | Loading finished |
| cfg_vid | output | 16 | Vendor ID |
| cfg_pid | output | 16 | Product ID |
| cfg_removable | output | 8 | Removable-port mask |
| cfg_port_cnt | output | 8 | Downstream port count |
| cfg_max_power | output | 8 | Maximum power value |
| cfg_vendor_len | output | 8 | Vendor string length |
| cfg_product_len | output | 8 | Product string length |
| cfg_serial_len | output | 8 | Serial string length |

## Verification
The assertions check the pin handover on every cycle: the data pin's output enable against the done flag, and the done flag staying high. They also check that the outgoing data bit does not move at a rising clock edge, that the clock stays low while chip select is low, and that the fields stay frozen once loading ends. Only the bench's scenarios can show the things that depend on what is stored in the EEPROM. These are the address order and the 25-edge framing seen from an EEPROM model, the byte-to-field mapping, acceptance and rejection by the checksum (including a zero sum), and the fall back to defaults when no device answers.

// File: rtl/cfgld_pkg.sv
package cfgld_pkg;

   // Word addresses (16-bit words) that carry decoded fields.
   localparam int unsigned W_VID   = 0;   // bytes 00h,01h
   localparam int unsigned W_PID   = 1;   // bytes 02h,03h
   localparam int unsigned W_CHK   = 2;   // byte 04h
   localparam int unsigned W_PORTS = 3;   // bytes 06h,07h
   localparam int unsigned W_PWR   = 4;   // byte 08h
   localparam int unsigned W_VLEN  = 8;   // byte 10h
   localparam int unsigned W_PLEN  = 32;  // byte 40h
   localparam int unsigned W_SLEN  = 56;  // byte 70h

   localparam int unsigned DATA_W  = 16;

   typedef struct packed {
      logic [15:0] vid;
      logic [15:0] pid;
      logic [7:0]  removable;
      logic [7:0]  port_cnt;
      logic [7:0]  max_power;
      logic [7:0]  vendor_len;
      logic [7:0]  product_len;
      logic [7:0]  serial_len;
   } hub_cfg_t;

   typedef enum logic [1:0] {U_IDLE, U_SHIFT, U_GAP} uw_state_t;

   typedef enum logic [1:0] {S_RUN, S_WAIT, S_FIN, S_DONE} seq_state_t;

endpackage

// File: rtl/cfgld_uwire.sv
module cfgld_uwire
   import cfgld_pkg::*;
#(
   parameter int unsigned ADDR_W   = 6,
   parameter int unsigned CLK_HALF = 4,
   parameter bit          DO_SYNC  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [ADDR_W-1:0] addr,
   input  logic              ee_do,
   output logic              ee_cs,
   output logic              ee_sk,
   output logic              ee_di,
   output logic              word_vld,
   output logic [DATA_W-1:0] word
);

   localparam int unsigned CMD_BITS = 3 + ADDR_W;
   localparam int unsigned TOT_BITS = CMD_BITS + DATA_W;
   localparam int unsigned DIV_W    = $clog2(CLK_HALF + 1);
   localparam int unsigned BIT_W    = $clog2(TOT_BITS + 1);
   localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(CLK_HALF - 1);
   localparam logic [BIT_W-1:0] CMD_IDX  = BIT_W'(CMD_BITS);
   localparam logic [BIT_W-1:0] LAST_IDX = BIT_W'(TOT_BITS - 1);

   uw_state_t            st_q;
   logic [DIV_W-1:0]     div_q;
   logic [BIT_W-1:0]     bit_q;
   logic [CMD_BITS-1:0]  cmd_q;
   logic [DATA_W-1:0]    shin_q;
   logic                 sk_q, cs_q, gap_half_q, vld_q;
   logic                 do_s;

   // Input path variant: two-stage synchronizer or direct sampling.
   generate
      if (DO_SYNC) begin : g_do_sync
         logic [1:0] sync_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sync_q <= 2'b11;
            else        sync_q <= {sync_q[0], ee_do};
         end
         assign do_s = sync_q[1];
      end else begin : g_do_raw
         assign do_s = ee_do;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q       <= U_IDLE;
         div_q      <= '0;
         bit_q      <= '0;
         cmd_q      <= '0;
         shin_q     <= '0;
         sk_q       <= 1'b0;
         cs_q       <= 1'b0;
         gap_half_q <= 1'b0;
         vld_q      <= 1'b0;
      end else begin
         vld_q <= 1'b0;
         unique case (st_q)
            U_IDLE: begin
               if (start) begin
                  cs_q  <= 1'b1;
                  sk_q  <= 1'b0;
                  div_q <= '0;
                  bit_q <= '0;
                  cmd_q <= {3'b110, addr};
                  st_q  <= U_SHIFT;
               end
            end
            U_SHIFT: begin
               if (div_q == DIV_LAST) begin
                  div_q <= '0;
                  if (!sk_q) begin
                     sk_q <= 1'b1;
                  end else begin
                     sk_q <= 1'b0;
                     if (bit_q >= CMD_IDX) shin_q <= {shin_q[DATA_W-2:0], do_s};
                     if (bit_q == LAST_IDX) begin
                        cs_q       <= 1'b0;
                        gap_half_q <= 1'b0;
                        st_q       <= U_GAP;
                     end else begin
                        bit_q <= bit_q + 1'b1;
                        cmd_q <= {cmd_q[CMD_BITS-2:0], 1'b0};
                     end
                  end
               end else begin
                  div_q <= div_q + 1'b1;
               end
            end
            U_GAP: begin
               if (div_q == DIV_LAST) begin
                  div_q <= '0;
                  if (gap_half_q) begin
                     vld_q <= 1'b1;
                     st_q  <= U_IDLE;
                  end else begin
                     gap_half_q <= 1'b1;
                  end
               end else begin
                  div_q <= div_q + 1'b1;
               end
            end
            default: st_q <= U_IDLE;
         endcase
      end
   end

   assign ee_cs    = cs_q;
   assign ee_sk    = sk_q;
   assign ee_di    = cs_q & cmd_q[CMD_BITS-1];
   assign word_vld = vld_q;
   assign word     = shin_q;

endmodule

// File: rtl/cfgld_image.sv
module cfgld_image
   import cfgld_pkg::*;
#(
   parameter int unsigned ADDR_W = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              word_vld,
   input  logic [ADDR_W-1:0] word_addr,
   input  logic [DATA_W-1:0] word,
   output hub_cfg_t          img,
   output logic              img_ok
);

   logic [15:0] vid_q, pid_q;
   logic [7:0]  chk_q, rem_q, ports_q, pwr_q, vlen_q, plen_q, slen_q;
   logic        ones_q;
   logic [7:0]  lo_b, hi_b, hdr_sum;

   assign lo_b = word[7:0];
   assign hi_b = word[15:8];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vid_q   <= '1;
         pid_q   <= '1;
         chk_q   <= '1;
         rem_q   <= '1;
         ports_q <= '1;
         pwr_q   <= '1;
         vlen_q  <= '1;
         plen_q  <= '1;
         slen_q  <= '1;
         ones_q  <= 1'b1;
      end else if (word_vld) begin
         if (word != '1) ones_q <= 1'b0;
         if (word_addr == ADDR_W'(W_VID))   vid_q   <= {hi_b, lo_b};
         if (word_addr == ADDR_W'(W_PID))   pid_q   <= {hi_b, lo_b};
         if (word_addr == ADDR_W'(W_CHK))   chk_q   <= lo_b;
         if (word_addr == ADDR_W'(W_PORTS)) begin
            rem_q   <= lo_b;
            ports_q <= hi_b;
         end
         if (word_addr == ADDR_W'(W_PWR))   pwr_q   <= lo_b;
         if (word_addr == ADDR_W'(W_VLEN))  vlen_q  <= lo_b;
         if (word_addr == ADDR_W'(W_PLEN))  plen_q  <= lo_b;
         if (word_addr == ADDR_W'(W_SLEN))  slen_q  <= lo_b;
      end
   end

   assign hdr_sum = vid_q[7:0] + vid_q[15:8] + pid_q[7:0] + pid_q[15:8];
   assign img_ok  = !ones_q && ((chk_q + hdr_sum) == 8'h00);

   assign img = '{vid: vid_q, pid: pid_q, removable: rem_q, port_cnt: ports_q,
                  max_power: pwr_q, vendor_len: vlen_q, product_len: plen_q,
                  serial_len: slen_q};

endmodule

// File: rtl/cfgld_pinmux.sv
module cfgld_pinmux (
   input  logic sel_led,
   input  logic ee_sk,
   input  logic ee_cs,
   input  logic ee_di,
   input  logic led_p1_green,
   input  logic led_p1_amber,
   input  logic led_p2_amber,
   input  logic led_p2_green,
   output logic pin_p1_green,
   output logic pin_p1_amber,
   output logic pin_p2_amber,
   output logic pin_p2_green_o,
   output logic pin_p2_green_oe
);

   assign pin_p1_green    = sel_led ? led_p1_green : ee_sk;
   assign pin_p1_amber    = sel_led ? led_p1_amber : ee_cs;
   assign pin_p2_amber    = sel_led ? led_p2_amber : ee_di;
   assign pin_p2_green_o  = sel_led & led_p2_green;
   assign pin_p2_green_oe = sel_led;

endmodule

// File: rtl/eeprom_cfg_loader.sv
module eeprom_cfg_loader
   import cfgld_pkg::*;
#(
   parameter int unsigned ADDR_W      = 6,
   parameter int unsigned CLK_HALF    = 4,
   parameter bit          DO_SYNC     = 1'b1,
   parameter logic [15:0] DEF_VID     = 16'hC0DE,
   parameter logic [15:0] DEF_PID     = 16'h0A50,
   parameter logic [7:0]  DEF_REMOV   = 8'h00,
   parameter logic [7:0]  DEF_PORTS   = 8'd4,
   parameter logic [7:0]  DEF_POWER   = 8'd50,
   parameter logic [7:0]  DEF_VLEN    = 8'd0,
   parameter logic [7:0]  DEF_PLEN    = 8'd0,
   parameter logic [7:0]  DEF_SLEN    = 8'd0
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        led_p1_green,
   input  logic        led_p1_amber,
   input  logic        led_p2_amber,
   input  logic        led_p2_green,
   output logic        pin_p1_green,
   output logic        pin_p1_amber,
   output logic        pin_p2_amber,
   output logic        pin_p2_green_o,
   output logic        pin_p2_green_oe,
   input  logic        pin_p2_green_i,
   output logic        load_done,
   output logic [15:0] cfg_vid,
   output logic [15:0] cfg_pid,
   output logic [7:0]  cfg_removable,
   output logic [7:0]  cfg_port_cnt,
   output logic [7:0]  cfg_max_power,
   output logic [7:0]  cfg_vendor_len,
   output logic [7:0]  cfg_product_len,
   output logic [7:0]  cfg_serial_len
);

   localparam int unsigned N_WORDS = 1 << ADDR_W;
   localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(N_WORDS - 1);
   localparam hub_cfg_t DEFAULTS = '{vid: DEF_VID, pid: DEF_PID,
      removable: DEF_REMOV, port_cnt: DEF_PORTS, max_power: DEF_POWER,
      vendor_len: DEF_VLEN, product_len: DEF_PLEN, serial_len: DEF_SLEN};

   generate
      if (ADDR_W < 6) begin : g_bad_addr
         $error("ADDR_W must reach word 56 (serial length)");
      end
      if (CLK_HALF < 2 || (DO_SYNC && CLK_HALF < 3)) begin : g_bad_half
         $error("CLK_HALF too small for the data input path");
      end
   endgenerate

   seq_state_t          seq_q;
   logic [ADDR_W-1:0]   addr_q;
   hub_cfg_t            cfg_q, img;
   logic                img_ok, start, word_vld;
   logic [DATA_W-1:0]   word;
   logic                ee_cs, ee_sk, ee_di;

   assign start = (seq_q == S_RUN);

   cfgld_uwire #(.ADDR_W(ADDR_W), .CLK_HALF(CLK_HALF), .DO_SYNC(DO_SYNC)) u_uwire (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .addr     (addr_q),
      .ee_do    (pin_p2_green_i),
      .ee_cs    (ee_cs),
      .ee_sk    (ee_sk),
      .ee_di    (ee_di),
      .word_vld (word_vld),
      .word     (word)
   );

   cfgld_image #(.ADDR_W(ADDR_W)) u_image (
      .clk       (clk),
      .rst_n     (rst_n),
      .word_vld  (word_vld),
      .word_addr (addr_q),
      .word      (word),
      .img       (img),
      .img_ok    (img_ok)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         seq_q  <= S_RUN;
         addr_q <= '0;
         cfg_q  <= DEFAULTS;
      end else begin
         unique case (seq_q)
            S_RUN:  seq_q <= S_WAIT;
            S_WAIT: begin
               if (word_vld) begin
                  if (addr_q == LAST_ADDR) begin
                     seq_q <= S_FIN;
                  end else begin
                     addr_q <= addr_q + 1'b1;
                     seq_q  <= S_RUN;
                  end
               end
            end
            S_FIN: begin
               cfg_q <= img_ok ? img : DEFAULTS;
               seq_q <= S_DONE;
            end
            default: seq_q <= S_DONE;
         endcase
      end
   end

   assign load_done = (seq_q == S_DONE);

   cfgld_pinmux u_pinmux (
      .sel_led         (load_done),
      .ee_sk           (ee_sk),
      .ee_cs           (ee_cs),
      .ee_di           (ee_di),
      .led_p1_green    (led_p1_green),
      .led_p1_amber    (led_p1_amber),
      .led_p2_amber    (led_p2_amber),
      .led_p2_green    (led_p2_green),
      .pin_p1_green    (pin_p1_green),
      .pin_p1_amber    (pin_p1_amber),
      .pin_p2_amber    (pin_p2_amber),
      .pin_p2_green_o  (pin_p2_green_o),
      .pin_p2_green_oe (pin_p2_green_oe)
   );

   assign cfg_vid         = cfg_q.vid;
   assign cfg_pid         = cfg_q.pid;
   assign cfg_removable   = cfg_q.removable;
   assign cfg_port_cnt    = cfg_q.port_cnt;
   assign cfg_max_power   = cfg_q.max_power;
   assign cfg_vendor_len  = cfg_q.vendor_len;
   assign cfg_product_len = cfg_q.product_len;
   assign cfg_serial_len  = cfg_q.serial_len;

endmodule

// File: rtl/cfgld_checker.sv
module cfgld_checker (
   input logic        clk,
   input logic        rst_n,
   input logic        load_done,
   input logic        pin_p1_green,
   input logic        pin_p1_amber,
   input logic        pin_p2_amber,
   input logic        pin_p2_green_oe,
   input logic [15:0] cfg_vid,
   input logic [15:0] cfg_pid,
   input logic [7:0]  cfg_port_cnt
);

   p_done_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
      load_done |=> load_done);

   p_cfg_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      load_done |=> ($stable(cfg_vid) && $stable(cfg_pid) && $stable(cfg_port_cnt)));

   p_oe_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !load_done |-> !pin_p2_green_oe);

   p_oe_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
      load_done |-> pin_p2_green_oe);

   p_di_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!load_done && $rose(pin_p1_green)) |-> $stable(pin_p2_amber));

   p_sk_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (!load_done && !pin_p1_amber) |-> !pin_p1_green);

endmodule

bind eeprom_cfg_loader cfgld_checker u_cfgld_checker (
   .clk             (clk),
   .rst_n           (rst_n),
   .load_done       (load_done),
   .pin_p1_green    (pin_p1_green),
   .pin_p1_amber    (pin_p1_amber),
   .pin_p2_amber    (pin_p2_amber),
   .pin_p2_green_oe (pin_p2_green_oe),
   .cfg_vid         (cfg_vid),
   .cfg_pid         (cfg_pid),
   .cfg_port_cnt    (cfg_port_cnt)
);

// File: tb/eeprom_cfg_loader_tb_top.sv
`timescale 1ns/1ps
module eeprom_cfg_loader_tb_top;

   localparam logic [15:0] DV = 16'hC0DE, DP = 16'h0A50;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic led_g1 = 0, led_a1 = 0, led_a2 = 0, led_g2 = 0;
   logic pin_g1, pin_a1, pin_a2, pin_g2_o, pin_g2_oe, dut_do;
   logic load_done;
   logic [15:0] cfg_vid, cfg_pid;
   logic [7:0]  cfg_rem, cfg_ports, cfg_pwr, cfg_vlen, cfg_plen, cfg_slen;

   int checks = 0, errors = 0;
   logic [7:0] mem [0:127];
   logic present = 1'b0;
   logic model_do = 1'b1;
   logic [8:0] cmd_sr = '0;
   int bit_cnt = 0, reads = 0, exp_addr = 0, cmd_errs = 0, len_errs = 0;

   always #2 clk = ~clk;   // 250 MHz

   assign dut_do = present ? model_do : 1'b1;

   eeprom_cfg_loader dut_i (
      .clk(clk), .rst_n(rst_n),
      .led_p1_green(led_g1), .led_p1_amber(led_a1),
      .led_p2_amber(led_a2), .led_p2_green(led_g2),
      .pin_p1_green(pin_g1), .pin_p1_amber(pin_a1), .pin_p2_amber(pin_a2),
      .pin_p2_green_o(pin_g2_o), .pin_p2_green_oe(pin_g2_oe), .pin_p2_green_i(dut_do),
      .load_done(load_done), .cfg_vid(cfg_vid), .cfg_pid(cfg_pid),
      .cfg_removable(cfg_rem), .cfg_port_cnt(cfg_ports), .cfg_max_power(cfg_pwr),
      .cfg_vendor_len(cfg_vlen), .cfg_product_len(cfg_plen), .cfg_serial_len(cfg_slen)
   );

   // Serial EEPROM model
   always @(posedge pin_g1) begin
      if (rst_n && !load_done && pin_a1) begin
         logic [8:0]  nx;
         logic [15:0] w;
         nx = {cmd_sr[7:0], pin_a2};
         if (bit_cnt < 9) cmd_sr = nx;
         if (bit_cnt == 8) begin
            if (nx[8:6] != 3'b110 || nx[5:0] != 6'(exp_addr)) cmd_errs++;
            model_do = 1'b0;
         end else if (bit_cnt >= 9 && bit_cnt <= 24) begin
            w = {mem[(2*exp_addr+1) & 127], mem[(2*exp_addr) & 127]};
            model_do = w[15-(bit_cnt-9)];
         end
         bit_cnt++;
      end
   end

   always @(negedge pin_a1) begin
      if (rst_n && !load_done) begin
         if (bit_cnt != 25) len_errs++;
         reads++;
         exp_addr++;
         bit_cnt = 0;
         model_do = 1'b1;
      end
   end

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [7:0] csum(input logic [7:0] a, b, c, d);
      return 8'(8'h00 - (a + b + c + d));
   endfunction

   task automatic fill_blank();
      for (int i = 0; i < 128; i++) mem[i] = 8'hFF;
   endtask

   task automatic run_load(input logic pres);
      int n;
      present = pres;
      {led_g1, led_a1, led_a2, led_g2} = 4'b0000;
      @(negedge clk);
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      bit_cnt = 0; reads = 0; exp_addr = 0; cmd_errs = 0; len_errs = 0;
      model_do = 1'b1;
      rst_n = 1'b1;
      n = 0;
      while (!load_done && n < 40000) begin
         @(negedge clk);
         n++;
      end
   endtask

   task automatic check_defaults(input string req);
      check(req, cfg_vid, DV);
      check(req, cfg_pid, DP);
      check(req, cfg_rem, 8'h00);
      check(req, cfg_ports, 8'd4);
      check(req, cfg_pwr, 8'd50);
      check(req, {cfg_vlen, cfg_plen, cfg_slen}, 24'h0);
   endtask

   task automatic t_reset_state();
      @(negedge clk);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      check("R1 done in reset", load_done, 1'b0);
      check_defaults("R1 reset defaults");
      rst_n = 1'b1;
      repeat (200) @(negedge clk);
      check("R1 done while loading", load_done, 1'b0);
      check_defaults("R1 loading defaults");
      check("R9 oe while loading", pin_g2_oe, 1'b0);
   endtask

   task automatic t_valid_image();
      fill_blank();
      mem[0] = 8'h34; mem[1] = 8'h12; mem[2] = 8'h78; mem[3] = 8'h56;
      mem[4] = csum(8'h34, 8'h12, 8'h78, 8'h56);
      mem[6] = 8'h06; mem[7] = 8'h03; mem[8] = 8'h32;
      mem[16] = 8'h0A; mem[64] = 8'h0C; mem[112] = 8'h08;
      run_load(1'b1);
      check("R8 done after load", load_done, 1'b1);
      check("R2 read count", reads, 64);
      check("R2 command and address", cmd_errs, 0);
      check("R3 edges per read", len_errs, 0);
      check("R4 R3 vid", cfg_vid, 16'h1234);
      check("R4 pid", cfg_pid, 16'h5678);
      check("R4 removable", cfg_rem, 8'h06);
      check("R4 port count", cfg_ports, 8'h03);
      check("R4 max power", cfg_pwr, 8'h32);
      check("R4 string lengths", {cfg_vlen, cfg_plen, cfg_slen}, 24'h0A0C08);
      // R9: pins return to LED function
      {led_g1, led_a1, led_a2, led_g2} = 4'b1011;
      @(negedge clk);
      check("R9 oe after done", pin_g2_oe, 1'b1);
      check("R9 pins follow LEDs", {pin_g1, pin_a1, pin_a2, pin_g2_o}, 4'b1011);
      {led_g1, led_a1, led_a2, led_g2} = 4'b0100;
      repeat (50) @(negedge clk);
      check("R9 pins follow LEDs 2", {pin_g1, pin_a1, pin_a2, pin_g2_o}, 4'b0100);
      check("R8 fields held", {cfg_vid, cfg_pid}, 32'h12345678);
      check("R8 done held", load_done, 1'b1);
   endtask

   task automatic t_zero_sum_image();
      fill_blank();
      mem[0] = 8'h00; mem[1] = 8'h00; mem[2] = 8'h00; mem[3] = 8'h00;
      mem[4] = 8'h00;
      mem[6] = 8'h0F; mem[7] = 8'h02; mem[8] = 8'hFA;
      mem[16] = 8'h2F; mem[64] = 8'h2E; mem[112] = 8'h10;
      run_load(1'b1);
      check("R5 zero-sum vid", cfg_vid, 16'h0000);
      check("R5 zero-sum pid", cfg_pid, 16'h0000);
      check("R5 zero-sum fields", {cfg_rem, cfg_ports, cfg_pwr}, 24'h0F02FA);
      check("R5 zero-sum lengths", {cfg_vlen, cfg_plen, cfg_slen}, 24'h2F2E10);
   endtask

   task automatic t_bad_checksum();
      fill_blank();
      mem[0] = 8'h34; mem[1] = 8'h12; mem[2] = 8'h78; mem[3] = 8'h56;
      mem[4] = csum(8'h34, 8'h12, 8'h78, 8'h56) + 8'h01;
      mem[6] = 8'h06; mem[7] = 8'h03; mem[8] = 8'h32;
      mem[16] = 8'h0A;
      run_load(1'b1);
      check("R6 done", load_done, 1'b1);
      check_defaults("R6 bad checksum defaults");
   endtask

   task automatic t_absent();
      fill_blank();
      run_load(1'b0);
      check("R7 done", load_done, 1'b1);
      check("R7 reads issued", reads, 64);
      check_defaults("R7 absent defaults");
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL R8 watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      fill_blank();
      repeat (3) @(negedge clk);
      t_reset_state();
      t_valid_image();
      t_zero_sum_image();
      t_bad_checksum();
      t_absent();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule